// File: doc/BRIEF.md
# Zero-Wait-State AHB SRAM Controller

This block is an AHB slave placed in front of a 32-bit synchronous single-port SRAM that supports byte writes. Every transfer finishes in a single data-phase clock. A read sends its word address to the RAM during the address phase, so the RAM answers in time for the data phase. A write only has its data during the data phase. The controller therefore either commits the write in that same cycle, when no read needs the RAM port, or keeps it in a one-entry hold register and commits it later.

AHB byte addresses are turned into RAM word addresses by dropping the two lowest address bits. The transfer size and those two low bits select the byte lanes a write touches, using little-endian mapping. A read of a word whose write is still held gets the held bytes on the lanes that write covers and the RAM bytes on all other lanes. The RAM may be built as one 32-bit array or as four byte-wide arrays, because each lane has its own write enable.

Top module: `ahb_sram_port`

## Requirements
- R1: `hreadyout` is 1 and `hresp` is 2'b00 (OKAY) in every cycle, so every data phase lasts one clock.
- R2: In the address phase of a read (`hsel`=1, `hready`=1, `htrans`=NONSEQ 2'b10 or SEQ 2'b11, `hwrite`=0), in that same cycle `ram_cs`=1, `ram_we`=4'b0000 and `ram_addr` = `haddr[AW-1:2]`.
- R3: Byte lane i is data bits [8i+7:8i]. A write with `hsize`=0 changes only lane `haddr[1:0]`. A write with `hsize`=1 changes lanes 0 and 1 when `haddr[1]`=0, and lanes 2 and 3 otherwise. A write with `hsize`=2 changes all four lanes. The bytes are taken from the same lanes of `hwdata`.
- R4: The data phase right after a read address phase drives all 32 bits of `hrdata` with the word as it stands after all earlier writes.
- R5: When a read's word matches a write that is still held, `hrdata` carries that write's bytes on the lanes it covers and the RAM bytes on the other lanes.
- R6: A write whose data phase falls in a cycle with no read address phase is committed in that cycle (`ram_we` = its lane mask, `ram_addr` = its word). Otherwise it is held and committed in the first later cycle that has no read address phase. At most one write is held at a time.
- R7: IDLE (2'b00) or BUSY (2'b01) transfers, `hsel`=0, or `hready`=0 during the address phase neither read the RAM nor queue a write, and they leave memory contents unchanged.
- R8: `ram_we` is nonzero only when `ram_cs`=1.
- R9: After reset there is no RAM access, no write is held, `hreadyout`=1 and `hresp`=OKAY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | AW | Byte address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write |
| hsize | input | 3 | Transfer size (0 byte, 1 halfword, 2 word) |
| hwdata | input | 32 | Write data (data phase) |
| hready | input | 1 | Bus-wide ready |
| hreadyout | output | 1 | Slave ready, always 1 |
| hresp | output | 2 | Response, always OKAY |
| hrdata | output | 32 | Read data |
| ram_cs | output | 1 | RAM access strobe |
| ram_we | output | 4 | Per-lane RAM write enables |
| ram_addr | output | AW-2 | RAM word address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, one cycle after the access |

## Verification
The bench sweeps every size and aligned offset. Each partial write lands on a word prefilled with a known pattern and is read back at once, while still held, and read back again after commit. This tells a wrong forwarding mask apart from a wrong write-enable mask. Write-then-read pairs separated by reads of other words show that the held write survives a stretch of busy RAM cycles. Idle, busy, deselected and not-ready transfers that carry write data show they are ignored. A long random mix weighted toward one word is checked against a byte-array model, which exposes ordering errors between direct commits, held commits and forwarding.

// File: rtl/ahb_sram_pkg.sv
package ahb_sram_pkg;

  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  typedef enum logic [2:0] {
    SZ_BYTE = 3'd0,
    SZ_HALF = 3'd1,
    SZ_WORD = 3'd2
  } hsize_e;

  // Little-endian lane selection from transfer size and low address bits.
  function automatic logic [LANES-1:0] lane_mask(input logic [2:0] size,
                                                 input logic [OFF_W-1:0] off);
    logic [LANES-1:0] m;
    case (hsize_e'(size))
      SZ_BYTE: m = LANES'(1) << off;
      SZ_HALF: m = off[1] ? 4'b1100 : 4'b0011;
      default: m = '1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/asp_addr_stage.sv
module asp_addr_stage import ahb_sram_pkg::*; #(
  parameter int AW  = 16,
  parameter int WAW = AW - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsel,
  input  logic [AW-1:0]    haddr,
  input  logic [1:0]       htrans,
  input  logic             hwrite,
  input  logic [2:0]       hsize,
  input  logic             hready,
  output logic             rd_ap,
  output logic [WAW-1:0]   ap_word,
  output logic             dph_wr,
  output logic [WAW-1:0]   dph_word,
  output logic [LANES-1:0] dph_be
);

  htrans_e tr;
  logic    ap_live;

  assign tr      = htrans_e'(htrans);
  assign ap_live = hsel && hready && (tr == TR_NONSEQ || tr == TR_SEQ);
  assign rd_ap   = ap_live && !hwrite;
  assign ap_word = haddr[AW-1:OFF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dph_wr   <= 1'b0;
      dph_word <= '0;
      dph_be   <= '0;
    end else if (hready) begin
      dph_wr <= ap_live && hwrite;
      if (ap_live) begin
        dph_word <= ap_word;
        dph_be   <= lane_mask(hsize, haddr[OFF_W-1:0]);
      end
    end
  end

endmodule

// File: rtl/asp_write_hold.sv
module asp_write_hold import ahb_sram_pkg::*; #(
  parameter int WAW = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_ap,
  input  logic              dph_wr,
  input  logic [WAW-1:0]    dph_word,
  input  logic [LANES-1:0]  dph_be,
  input  logic [WORD_W-1:0] hwdata,
  output logic              pend_valid,
  output logic [WAW-1:0]    pend_word,
  output logic [LANES-1:0]  pend_be,
  output logic [WORD_W-1:0] pend_data,
  output logic              cm_en,
  output logic [WAW-1:0]    cm_word,
  output logic [LANES-1:0]  cm_be,
  output logic [WORD_W-1:0] cm_data
);

  logic port_free;
  logic park;

  assign port_free = !rd_ap;
  assign park      = dph_wr && rd_ap;

  // Commit source: the held write first, else the write in its data phase.
  always_comb begin
    cm_en   = port_free && (pend_valid || dph_wr);
    cm_word = pend_valid ? pend_word : dph_word;
    cm_be   = pend_valid ? pend_be   : dph_be;
    cm_data = pend_valid ? pend_data : hwdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_word  <= '0;
      pend_be    <= '0;
      pend_data  <= '0;
    end else begin
      if (pend_valid && port_free) pend_valid <= 1'b0;
      if (park) begin
        pend_valid <= 1'b1;
        pend_word  <= dph_word;
        pend_be    <= dph_be;
        pend_data  <= hwdata;
      end
    end
  end

endmodule

// File: rtl/asp_read_merge.sv
module asp_read_merge import ahb_sram_pkg::*; #(
  parameter int WAW = 14
) (
  input  logic [WAW-1:0]    dph_word,
  input  logic              pend_valid,
  input  logic [WAW-1:0]    pend_word,
  input  logic [LANES-1:0]  pend_be,
  input  logic [WORD_W-1:0] pend_data,
  input  logic [WORD_W-1:0] ram_rdata,
  output logic [WORD_W-1:0] hrdata
);

  logic hit;
  assign hit = pend_valid && (pend_word == dph_word);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign hrdata[i*BYTE_W +: BYTE_W] = (hit && pend_be[i]) ?
                                        pend_data[i*BYTE_W +: BYTE_W] :
                                        ram_rdata[i*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/ahb_sram_port.sv
module ahb_sram_port import ahb_sram_pkg::*; #(
  parameter int AW = 16
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  logic              hsel,
  input  logic [AW-1:0]     haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [WORD_W-1:0] hwdata,
  input  logic              hready,
  output logic              hreadyout,
  output logic [1:0]        hresp,
  output logic [WORD_W-1:0] hrdata,
  output logic              ram_cs,
  output logic [LANES-1:0]  ram_we,
  output logic [AW-3:0]     ram_addr,
  output logic [WORD_W-1:0] ram_wdata,
  input  logic [WORD_W-1:0] ram_rdata
);

  localparam int WAW = AW - OFF_W;

  logic              rd_ap;
  logic [WAW-1:0]    ap_word;
  logic              dph_wr;
  logic [WAW-1:0]    dph_word;
  logic [LANES-1:0]  dph_be;
  logic              pend_valid;
  logic [WAW-1:0]    pend_word;
  logic [LANES-1:0]  pend_be;
  logic [WORD_W-1:0] pend_data;
  logic              cm_en;
  logic [WAW-1:0]    cm_word;
  logic [LANES-1:0]  cm_be;
  logic [WORD_W-1:0] cm_data;

  asp_addr_stage #(.AW(AW), .WAW(WAW)) u_addr (
    .clk(hclk), .rst_n(hresetn), .hsel(hsel), .haddr(haddr),
    .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hready(hready),
    .rd_ap(rd_ap), .ap_word(ap_word), .dph_wr(dph_wr),
    .dph_word(dph_word), .dph_be(dph_be)
  );

  asp_write_hold #(.WAW(WAW)) u_hold (
    .clk(hclk), .rst_n(hresetn), .rd_ap(rd_ap), .dph_wr(dph_wr),
    .dph_word(dph_word), .dph_be(dph_be), .hwdata(hwdata),
    .pend_valid(pend_valid), .pend_word(pend_word), .pend_be(pend_be),
    .pend_data(pend_data), .cm_en(cm_en), .cm_word(cm_word),
    .cm_be(cm_be), .cm_data(cm_data)
  );

  asp_read_merge #(.WAW(WAW)) u_merge (
    .dph_word(dph_word), .pend_valid(pend_valid), .pend_word(pend_word),
    .pend_be(pend_be), .pend_data(pend_data), .ram_rdata(ram_rdata),
    .hrdata(hrdata)
  );

  assign hreadyout = 1'b1;
  assign hresp     = 2'b00;
  assign ram_cs    = rd_ap || cm_en;
  assign ram_we    = cm_en ? cm_be : '0;
  assign ram_addr  = rd_ap ? ap_word : cm_word;
  assign ram_wdata = cm_data;

endmodule

// File: rtl/ahb_sram_port_chk.sv
module ahb_sram_port_chk #(
  parameter int AW = 16
) (
  input logic          hclk,
  input logic          hresetn,
  input logic [AW-1:0] haddr,
  input logic          hreadyout,
  input logic [1:0]    hresp,
  input logic          rd_ap,
  input logic          dph_wr,
  input logic          pend_valid,
  input logic          ram_cs,
  input logic [3:0]    ram_we,
  input logic [AW-3:0] ram_addr
);

  // R1
  always_okay_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    hreadyout && hresp == 2'b00);

  // R2
  rd_port_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    rd_ap |-> (ram_cs && ram_we == 4'b0000 && ram_addr == haddr[AW-1:2]));

  // R6
  commit_now_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (dph_wr && !rd_ap) |-> (ram_we != 4'b0000));

  // R6
  single_hold_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    dph_wr |-> !pend_valid);

  // R6
  drain_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (pend_valid && !rd_ap) |=> !pend_valid);

  // R8
  we_needs_cs_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (ram_we != 4'b0000) |-> ram_cs);

  // R7
  quiet_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (!rd_ap && !dph_wr && !pend_valid) |-> !ram_cs);

endmodule

bind ahb_sram_port ahb_sram_port_chk #(.AW(AW)) u_chk (
  .hclk(hclk), .hresetn(hresetn), .haddr(haddr), .hreadyout(hreadyout),
  .hresp(hresp), .rd_ap(rd_ap), .dph_wr(dph_wr), .pend_valid(pend_valid),
  .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr)
);

// File: tb/ahb_sram_port_test.sv
module ahb_sram_port_test;

  localparam int AW     = 6;
  localparam int NWORDS = 1 << (AW - 2);

  logic          clk = 1'b0;
  logic          hresetn, hsel, hwrite, hready, hreadyout, ram_cs;
  logic [AW-1:0] haddr;
  logic [1:0]    htrans, hresp;
  logic [2:0]    hsize;
  logic [31:0]   hwdata, hrdata, ram_wdata, ram_rdata;
  logic [3:0]    ram_we;
  logic [AW-3:0] ram_addr;

  always #5 clk = ~clk;

  ahb_sram_port #(.AW(AW)) uut (
    .hclk(clk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr),
    .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata),
    .hready(hready), .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
    .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // Stand-in synchronous byte-write SRAM.
  logic [7:0] sram [NWORDS][4];
  always @(posedge clk) begin
    if (!hresetn) begin
      for (int w = 0; w < NWORDS; w++)
        for (int b = 0; b < 4; b++) sram[w][b] <= 8'h00;
      ram_rdata <= '0;
    end else if (ram_cs) begin
      if (ram_we == 4'b0000)
        ram_rdata <= {sram[ram_addr][3], sram[ram_addr][2], sram[ram_addr][1], sram[ram_addr][0]};
      for (int b = 0; b < 4; b++)
        if (ram_we[b]) sram[ram_addr][b] <= ram_wdata[b*8 +: 8];
    end
  end

  // Reference byte memory.
  logic [7:0] ref_mem [NWORDS][4];

  int checks = 0;
  int fails  = 0;
  bit p_rd = 0, p_wr = 0;
  logic [31:0]   p_exp, p_wdata;
  logic [AW-1:0] p_addr;
  logic [2:0]    p_size;
  string         p_tag;

  function automatic bit touches(input logic [2:0] sz, input int off, input int lane);
    if (sz == 3'd0) return lane == off;
    if (sz == 3'd1) return (lane / 2) == (off / 2);
    return 1'b1;
  endfunction

  function automatic logic [3:0] mask_of(input logic [2:0] sz, input logic [AW-1:0] a);
    logic [3:0] m;
    for (int l = 0; l < 4; l++) m[l] = touches(sz, int'(a % 4), l);
    return m;
  endfunction

  function automatic logic [31:0] ref_word(input int w);
    logic [31:0] v;
    for (int l = 0; l < 4; l++) v[l*8 +: 8] = ref_mem[w][l];
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // kind: 0 read, 1 write, 2 IDLE, 3 BUSY, 4 deselected, 5 hready low
  task automatic step(input int kind, input logic [AW-1:0] a, input logic [2:0] sz,
                      input logic [31:0] d, input string tag);
    @(negedge clk);
    check(hreadyout === 1'b1 && hresp === 2'b00, "R1", {hreadyout, hresp}, 32'h4);
    if (p_rd) check(hrdata === p_exp, p_tag, hrdata, p_exp);
    hwdata = p_wr ? p_wdata : 32'hDEAD_BEEF;
    hsel = 1'b1; hready = 1'b1; htrans = 2'b10; hwrite = 1'b0;
    haddr = a; hsize = sz;
    case (kind)
      1: hwrite = 1'b1;
      2: begin htrans = 2'b00; hwrite = 1'b1; end
      3: begin htrans = 2'b01; hwrite = 1'b1; end
      4: begin hsel = 1'b0; hwrite = 1'b1; end
      5: begin hready = 1'b0; hwrite = 1'b1; end
      default: ;
    endcase
    #1;
    check(ram_we == 4'b0000 || ram_cs === 1'b1, "R8", {ram_cs, ram_we}, 32'h10);
    if (kind == 0)
      check(ram_cs === 1'b1 && ram_we === 4'b0000 && ram_addr === a[AW-1:2], "R2",
            {ram_cs, ram_we, ram_addr}, {1'b1, 4'b0000, a[AW-1:2]});
    else if (p_wr)
      check(ram_we === mask_of(p_size, p_addr) && ram_addr === p_addr[AW-1:2], "R6",
            {ram_we, ram_addr}, {mask_of(p_size, p_addr), p_addr[AW-1:2]});
    p_rd = (kind == 0);
    p_wr = (kind == 1);
    p_tag = tag;
    if (kind == 0) p_exp = ref_word(int'(a >> 2));
    if (kind == 1) begin
      p_addr = a; p_size = sz; p_wdata = d;
      for (int l = 0; l < 4; l++)
        if (touches(sz, int'(a % 4), l)) ref_mem[a >> 2][l] = d[l*8 +: 8];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    for (int w = 0; w < NWORDS; w++)
      for (int b = 0; b < 4; b++) ref_mem[w][b] = 8'h00;
    hresetn = 1'b0; hsel = 1'b0; hready = 1'b1; htrans = 2'b00; hwrite = 1'b0;
    haddr = '0; hsize = 3'd0; hwdata = '0;
    repeat (3) @(negedge clk);
    hresetn = 1'b1;
    // R9: quiet after reset
    repeat (2) begin
      @(negedge clk);
      check(ram_cs === 1'b0 && ram_we === 4'b0000 && hreadyout === 1'b1 && hresp === 2'b00,
            "R9", {ram_cs, ram_we, hreadyout, hresp}, 32'h4);
    end

    // Size x offset sweep: R3 lanes, R5 forwarding, R6 hold across reads.
    for (int sz = 0; sz < 3; sz++) begin
      for (int off = 0; off < 4; off += (1 << sz)) begin
        logic [AW-3:0] w;
        logic [AW-3:0] o;
        w = (AW-2)'(sz * 4 + off + 1);
        o = w ^ 1;
        step(1, {w, 2'b00}, 3'd2, 32'hA0B0C0D0 ^ {28'h0, w}, "R3");
        step(1, {w, 2'(off)}, 3'(sz), 32'h1122_3344 + off, "R3");
        step(0, {w, 2'b00}, 3'd2, 0, "R5");
        step(0, {o, 2'b00}, 3'd2, 0, "R4");
        step(0, {w, 2'b00}, 3'd2, 0, "R5");
        step(2, '0, 3'd0, 0, "R7");
        step(0, {w, 2'b00}, 3'd2, 0, "R3");
      end
    end

    // Ignored transfer kinds carrying write data: R7.
    for (int k = 2; k < 6; k++) begin
      step(2, '0, 3'd0, 0, "R7");
      step(k, 6'h14, 3'd2, 32'hFFFF_FFFF, "R7");
      step(2, '0, 3'd0, 0, "R7");
      step(0, 6'h14, 3'd2, 0, "R7");
    end

    // Random mix biased to one word.
    begin
      logic [AW-1:0] last_a;
      bit            last_wr;
      last_a = '0;
      last_wr = 0;
      for (int n = 0; n < 4000; n++) begin
        int unsigned r;
        int kind;
        logic [2:0] sz;
        logic [AW-1:0] a;
        r  = $urandom;
        sz = 3'(r % 3);
        a  = ((r >> 4) % 2 == 0) ? {last_a[AW-1:2], 2'(r >> 8)} : AW'(r >> 12);
        a  = a & ~AW'((1 << sz) - 1);
        case ((r >> 20) % 10)
          0, 1, 2, 3: kind = 0;
          4, 5, 6, 7: kind = 1;
          default:    kind = 2 + int'((r >> 24) % 4);
        endcase
        if (kind == 5 && (p_rd || p_wr)) step(2, '0, 3'd0, 0, "R7");
        if (kind == 0)
          step(0, a, 3'd2, 0, (last_wr && last_a[AW-1:2] == a[AW-1:2]) ? "R5" : "R4");
        else
          step(kind, a, sz, $urandom, "R7");
        last_wr = (kind == 1);
        if (kind <= 1) last_a = a;
      end
    end

    step(2, '0, 3'd0, 0, "R7");
    step(2, '0, 3'd0, 0, "R7");
    summary();
    $finish;
  end

endmodule